// File: doc/BRIEF.md
# Frame-Sync Loss Power-Down Controller

This block supervises the frame-sync activity and the master clock of a four-channel telephony PCM port and decides when each channel, or the whole port, should be held in power-down. It runs on a free-running reference clock. From that clock it derives a frame-period timebase and, for each channel, counts the frame periods in which neither the transmit nor the receive sync showed a rising edge. A channel whose syncs have both stayed silent for long enough is flagged as powered down. When a sync comes back, the channel runs through a timed wake phase before it is reported ready again.

A toggle register clocked by the master clock is watched from the reference domain, so a stopped master clock is caught even though nothing in the master-clock domain can report it. The port as a whole enters global power-down for any of three causes: the master clock stops, every sync the current bus mode cares about is lost, or all four external power-down requests are asserted. Global power-down ends with a longer timed wake phase. In the wide (32-bit) bus mode the syncs of channel 0 alone govern all four channels, and a shorter silence limit applies.

Each external request line forces its own channel down. All delays are parameters counted in frame periods, so a bench can use short settings.

Top module: `fsl_pd_ctrl`

## Requirements
- R1: After reset every channel is ready, no channel power-down flag is set and the global flag is low. A channel is never flagged ready and powered down at the same time.
- R2: If only one of a channel's two syncs (transmit or receive) stops while the other keeps pulsing, the channel stays ready for any length of time.
- R3: In narrow mode (`wide_mode`=0), a channel whose transmit and receive syncs both show no rising edge for MISS_LIMIT consecutive frame periods (FRAME_DIV reference cycles each) sets its power-down flag and drops its ready flag.
- R4: When a sync of a powered-down channel resumes, the channel's power-down flag clears at the following frame boundary. The channel stays not-ready for WAKE_FRAMES frame periods and then becomes ready.
- R5: `pdn[i]`=1 sets `ch_pd[i]` on the next cycle and leaves the other channels unaffected. When it is released, the channel goes through the R4 wake phase.
- R6: `glob_pd` rises on the cycle after all four `pdn` bits are 1, or after every channel has reached its silence limit. Three asserted `pdn` bits alone do not set it.
- R7: In wide mode (`wide_mode`=1), only the channel-0 syncs count for all channels, so silent syncs on channels 1 to 3 have no effect. Silence on channel 0 for WIDE_LIMIT frame periods powers down all four channels.
- R8: If the master clock shows no edge for MCLK_TIMEOUT reference cycles, `glob_pd` is set. It stays set for as long as the master clock is absent, even while syncs keep arriving.
- R9: Once every global cause is gone, `glob_pd` stays high for GLOBAL_WAKE more frame periods and then clears. While `glob_pd` is high, every `ch_ready` bit is 0 and every `ch_pd` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master/bit clock being monitored |
| fsx | input | NCH | Transmit frame syncs, one per channel |
| fsr | input | NCH | Receive frame syncs, one per channel |
| pdn | input | NCH | External power-down requests, one per channel, synchronous to clk |
| wide_mode | input | 1 | 1 = wide bus mode, with channel 0 syncs governing all channels |
| ch_pd | output | NCH | Per-channel power-down flags |
| glob_pd | output | 1 | Global power-down flag |
| ch_ready | output | NCH | Per-channel ready flags |

## Verification
Sync edges pass through a two-flop synchronizer and are only acted on at a frame tick, so the point at which a silence limit is reached can vary by about one frame period. The bench therefore samples each silence or wake result a few frames before its nominal frame, where the old value must still hold, and a few frames after it, where the new value must hold. A `pdn` request acts on the very next reference cycle and is checked two cycles after it is driven. Master-clock loss is checked at 8 reference cycles, where the flag must still be clear, and at 40 cycles, where it must be set. All outputs are sampled 2 ns after a rising edge, and inputs change on falling edges.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    typedef enum logic [1:0] {CH_ACTIVE, CH_DOWN, CH_WAKE} ch_state_e;
    typedef enum logic [1:0] {GL_RUN, GL_DOWN, GL_WAKE} gl_state_e;

    typedef struct packed {
        logic tx;
        logic rx;
    } sync_pair_t;

    function automatic logic pair_active(sync_pair_t p);
        return p.tx | p.rx;
    endfunction
endpackage

// File: rtl/fsl_frame_tick.sv
module fsl_frame_tick #(
    parameter int DIV = 12500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = $clog2(DIV + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == W'(DIV - 1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/fsl_mclk_mon.sv
module fsl_mclk_mon #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk,
    output logic lost
);
    localparam int W = $clog2(TIMEOUT + 1);
    logic         tog_q;
    logic [2:0]   smp_q;
    logic [W-1:0] idle_q;

    always_ff @(posedge mclk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= ~tog_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= '0;
            idle_q <= '0;
        end else begin
            smp_q <= {smp_q[1:0], tog_q};
            if (smp_q[2] ^ smp_q[1]) idle_q <= '0;
            else if (!lost)          idle_q <= idle_q + 1'b1;
        end
    end

    assign lost = (idle_q >= W'(TIMEOUT));
endmodule

// File: rtl/fsl_sync_edge.sv
module fsl_sync_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/fsl_chan_fsm.sv
module fsl_chan_fsm
    import fsl_pkg::*;
#(
    parameter int MISS_LIMIT  = 32,
    parameter int WIDE_LIMIT  = 4,
    parameter int WAKE_FRAMES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wide,
    input  logic act,
    input  logic pdn,
    output logic full,
    output logic down,
    output logic active
);
    localparam int CW = $clog2(MISS_LIMIT + 1);
    localparam int WW = $clog2(WAKE_FRAMES + 1);

    ch_state_e    state_q;
    logic         seen_q;
    logic [CW-1:0] miss_q;
    logic [WW-1:0] wake_q;
    logic [CW-1:0] limit;

    assign limit  = wide ? CW'(WIDE_LIMIT) : CW'(MISS_LIMIT);
    assign full   = (miss_q >= limit);
    assign down   = (state_q == CH_DOWN);
    assign active = (state_q == CH_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            miss_q  <= '0;
            wake_q  <= '0;
            state_q <= CH_ACTIVE;
        end else begin
            if (tick) begin
                seen_q <= 1'b0;
                if (seen_q || act) miss_q <= '0;
                else if (!full)    miss_q <= miss_q + 1'b1;
            end else if (act) begin
                seen_q <= 1'b1;
            end

            unique case (state_q)
                CH_ACTIVE: if (pdn || full) state_q <= CH_DOWN;
                CH_DOWN: if (!pdn && !full) begin
                    state_q <= CH_WAKE;
                    wake_q  <= '0;
                end
                CH_WAKE: begin
                    if (pdn || full) state_q <= CH_DOWN;
                    else if (tick) begin
                        if (wake_q == WW'(WAKE_FRAMES - 1)) state_q <= CH_ACTIVE;
                        else wake_q <= wake_q + 1'b1;
                    end
                end
                default: state_q <= CH_DOWN;
            endcase
        end
    end
endmodule

// File: rtl/fsl_pd_ctrl.sv
module fsl_pd_ctrl
    import fsl_pkg::*;
#(
    parameter int NCH           = 4,
    parameter int FRAME_DIV     = 12500,
    parameter int MISS_LIMIT    = 32,
    parameter int WIDE_LIMIT    = 4,
    parameter int WAKE_FRAMES   = 32,
    parameter int GLOBAL_WAKE   = 800,
    parameter int MCLK_TIMEOUT  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mclk,
    input  logic [NCH-1:0] fsx,
    input  logic [NCH-1:0] fsr,
    input  logic [NCH-1:0] pdn,
    input  logic           wide_mode,
    output logic [NCH-1:0] ch_pd,
    output logic           glob_pd,
    output logic [NCH-1:0] ch_ready
);
    localparam int GW = $clog2(GLOBAL_WAKE + 1);

    logic           tick, mclk_lost;
    logic [NCH-1:0] fsx_rise, fsr_rise;
    logic [NCH-1:0] full_v, down_v, active_v;
    sync_pair_t     pair [NCH];
    gl_state_e      gst_q;
    logic [GW-1:0]  gcnt_q;
    logic           enter;

    fsl_frame_tick #(.DIV(FRAME_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));
    fsl_mclk_mon #(.TIMEOUT(MCLK_TIMEOUT)) u_mon (.clk(clk), .rst(rst), .mclk(mclk), .lost(mclk_lost));
    fsl_sync_edge #(.N(NCH)) u_fsx (.clk(clk), .rst(rst), .din(fsx), .rise(fsx_rise));
    fsl_sync_edge #(.N(NCH)) u_fsr (.clk(clk), .rst(rst), .din(fsr), .rise(fsr_rise));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic act;
        assign pair[i] = '{tx: fsx_rise[i], rx: fsr_rise[i]};
        assign act = wide_mode ? pair_active(pair[0]) : pair_active(pair[i]);

        fsl_chan_fsm #(
            .MISS_LIMIT (MISS_LIMIT),
            .WIDE_LIMIT (WIDE_LIMIT),
            .WAKE_FRAMES(WAKE_FRAMES)
        ) u_fsm (
            .clk(clk), .rst(rst), .tick(tick), .wide(wide_mode),
            .act(act), .pdn(pdn[i]),
            .full(full_v[i]), .down(down_v[i]), .active(active_v[i])
        );
    end

    assign enter = mclk_lost | (&pdn) | (&full_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            gst_q  <= GL_RUN;
            gcnt_q <= '0;
        end else begin
            unique case (gst_q)
                GL_RUN:  if (enter) gst_q <= GL_DOWN;
                GL_DOWN: if (!enter) begin
                    gst_q  <= GL_WAKE;
                    gcnt_q <= '0;
                end
                GL_WAKE: begin
                    if (enter) gst_q <= GL_DOWN;
                    else if (tick) begin
                        if (gcnt_q == GW'(GLOBAL_WAKE - 1)) gst_q <= GL_RUN;
                        else gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                default: gst_q <= GL_DOWN;
            endcase
        end
    end

    assign glob_pd  = (gst_q != GL_RUN);
    assign ch_pd    = down_v | {NCH{glob_pd}};
    assign ch_ready = active_v & {NCH{~glob_pd}};
endmodule

// File: rtl/fsl_pd_ctrl_chk.sv
module fsl_pd_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] pdn,
    input logic [NCH-1:0] ch_pd,
    input logic           glob_pd,
    input logic [NCH-1:0] ch_ready
);
    // R6: all requests asserted drives the global flag on the next cycle
    a_r6_all_pdn_global: assert property (@(posedge clk) disable iff (rst)
        (&pdn) |=> glob_pd);

    // R9: no channel may be ready during global power-down
    a_r9_glob_blocks_ready: assert property (@(posedge clk) disable iff (rst)
        glob_pd |-> (ch_ready == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R5: a request forces its channel down on the next cycle
        a_r5_pdn_forces_down: assert property (@(posedge clk) disable iff (rst)
            pdn[i] |=> ch_pd[i]);

        // R1: ready and powered-down never together
        a_r1_ready_excl_pd: assert property (@(posedge clk) disable iff (rst)
            !(ch_ready[i] && ch_pd[i]));

        // R4: leaving a local power-down passes through a not-ready wake phase
        a_r4_wake_not_ready: assert property (@(posedge clk) disable iff (rst)
            ($fell(ch_pd[i]) && !glob_pd && !$past(glob_pd)) |-> !ch_ready[i]);
    end
endmodule

bind fsl_pd_ctrl fsl_pd_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .pdn(pdn), .ch_pd(ch_pd),
    .glob_pd(glob_pd), .ch_ready(ch_ready)
);

// File: tb/fsl_pd_ctrl_tb.sv
`timescale 1ns/1ps
module fsl_pd_ctrl_tb;
    localparam int FD   = 16;
    localparam int MISS = 32;
    localparam int WIDE = 4;
    localparam int WAKE = 8;
    localparam int GWK  = 20;
    localparam int MTO  = 16;

    logic       clk = 1'b0, rst = 1'b1, mclk = 1'b0, mclk_en = 1'b1;
    logic [3:0] fsx = '0, fsr = '0, pdn = '0;
    logic [3:0] fsx_en = 4'hF, fsr_en = 4'hF;
    logic       wide_mode = 1'b0;
    logic [3:0] ch_pd, ch_ready;
    logic       glob_pd;
    int         vectors = 0, fails = 0;
    bit         done = 0;

    always #5 clk = ~clk;
    always #20 if (mclk_en) mclk = ~mclk;

    fsl_pd_ctrl #(
        .NCH(4), .FRAME_DIV(FD), .MISS_LIMIT(MISS), .WIDE_LIMIT(WIDE),
        .WAKE_FRAMES(WAKE), .GLOBAL_WAKE(GWK), .MCLK_TIMEOUT(MTO)
    ) u_dut (
        .clk(clk), .rst(rst), .mclk(mclk), .fsx(fsx), .fsr(fsr), .pdn(pdn),
        .wide_mode(wide_mode), .ch_pd(ch_pd), .glob_pd(glob_pd), .ch_ready(ch_ready)
    );

    // frame-sync generator: 2-cycle pulse once per FD cycles
    initial begin
        int fc = 0;
        forever begin
            @(negedge clk);
            fsx = (fc < 2) ? fsx_en : 4'h0;
            fsr = (fc < 2) ? fsr_en : 4'h0;
            fc  = (fc == FD - 1) ? 0 : fc + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_frames(input int n);
        wait_cyc(n * FD);
    endtask

    task automatic drive(input logic [3:0] p);
        @(negedge clk);
        pdn = p;
    endtask

    task automatic t_reset;
        wait_cyc(4);
        chk("R1 ready after reset", ch_ready, 4'hF);
        chk("R1 pd after reset", ch_pd, 4'h0);
        chk("R1 glob after reset", glob_pd, 1'b0);
    endtask

    task automatic t_one_missing;
        fsx_en[1] = 1'b0;
        wait_frames(MISS + 8);
        chk("R2 tx-only loss keeps ready", ch_ready, 4'hF);
        fsx_en[1] = 1'b1;
        fsr_en[2] = 1'b0;
        wait_frames(MISS + 8);
        chk("R2 rx-only loss keeps ready", ch_ready, 4'hF);
        fsr_en[2] = 1'b1;
        wait_frames(2);
    endtask

    task automatic t_both_missing;
        fsx_en[2] = 1'b0;
        fsr_en[2] = 1'b0;
        wait_frames(MISS - 2);
        chk("R3 before limit pd", ch_pd[2], 1'b0);
        wait_frames(6);
        chk("R3 after limit pd", ch_pd[2], 1'b1);
        chk("R3 after limit ready", ch_ready, 4'hB);
        chk("R3 glob stays low", glob_pd, 1'b0);
        fsx_en[2] = 1'b1;
        wait_frames(3);
        chk("R4 pd cleared in wake", ch_pd[2], 1'b0);
        chk("R4 not ready in wake", ch_ready[2], 1'b0);
        wait_frames(WAKE + 4);
        chk("R4 ready after wake", ch_ready, 4'hF);
        fsr_en[2] = 1'b1;
    endtask

    task automatic t_pdn_single;
        drive(4'h8);
        wait_cyc(2);
        chk("R5 pdn forces pd", ch_pd, 4'h8);
        chk("R5 others ready", ch_ready, 4'h7);
        drive(4'h7);
        wait_cyc(2);
        chk("R6 three pdn no glob", glob_pd, 1'b0);
        chk("R5 three pdn pd", ch_pd, 4'h7);
        drive(4'h0);
        wait_frames(3);
        chk("R5 waking not ready", ch_ready, 4'h0);
        chk("R5 waking pd clear", ch_pd, 4'h0);
        wait_frames(WAKE + 4);
        chk("R5 ready after release", ch_ready, 4'hF);
    endtask

    task automatic t_pdn_all;
        drive(4'hF);
        wait_cyc(2);
        chk("R6 all pdn glob", glob_pd, 1'b1);
        chk("R9 no ready in glob", ch_ready, 4'h0);
        drive(4'h0);
        wait_frames(GWK / 2);
        chk("R9 glob held in wake", glob_pd, 1'b1);
        chk("R9 pd all in wake", ch_pd, 4'hF);
        wait_frames(GWK / 2 + 6);
        chk("R9 glob cleared", glob_pd, 1'b0);
        chk("R9 ready after glob", ch_ready, 4'hF);
    endtask

    task automatic t_all_sync_lost;
        fsx_en = 4'h0;
        fsr_en = 4'h0;
        wait_frames(MISS + 4);
        chk("R6 all syncs lost glob", glob_pd, 1'b1);
        chk("R6 all syncs lost pd", ch_pd, 4'hF);
        fsr_en = 4'h1;
        fsx_en = 4'hF;
        fsr_en = 4'hF;
        wait_frames(GWK + 6);
        chk("R9 recover after sync return", ch_ready, 4'hF);
        chk("R9 glob low after sync return", glob_pd, 1'b0);
    endtask

    task automatic t_wide;
        wide_mode = 1'b1;
        fsx_en = 4'h1;
        fsr_en = 4'h1;
        wait_frames(MISS + 4);
        chk("R7 ch1-3 silent ignored", ch_ready, 4'hF);
        fsx_en = 4'h0;
        fsr_en = 4'h0;
        wait_frames(WIDE - 2);
        chk("R7 before wide limit", ch_pd, 4'h0);
        wait_frames(6);
        chk("R7 all down after wide limit", ch_pd, 4'hF);
        chk("R7 glob in wide loss", glob_pd, 1'b1);
        fsr_en = 4'h1;
        wait_frames(GWK + 6);
        chk("R7 ch0 alone restores all", ch_ready, 4'hF);
        fsx_en = 4'hF;
        fsr_en = 4'hF;
        wait_frames(2);
        wide_mode = 1'b0;
        wait_frames(2);
        chk("R7 back to narrow ready", ch_ready, 4'hF);
    endtask

    task automatic t_mclk;
        @(negedge clk);
        mclk_en = 1'b0;
        wait_cyc(8);
        chk("R8 short gap no glob", glob_pd, 1'b0);
        wait_cyc(32);
        chk("R8 mclk lost glob", glob_pd, 1'b1);
        wait_frames(GWK + 6);
        chk("R8 held while mclk absent", glob_pd, 1'b1);
        chk("R9 ready blocked", ch_ready, 4'h0);
        mclk_en = 1'b1;
        wait_frames(GWK / 2);
        chk("R9 wake after mclk", glob_pd, 1'b1);
        wait_frames(GWK / 2 + 6);
        chk("R9 exit after mclk", glob_pd, 1'b0);
        chk("R9 ready after mclk", ch_ready, 4'hF);
    endtask

    initial begin
        wait_cyc(6);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_one_missing();
        t_both_missing();
        t_pdn_single();
        t_pdn_all();
        t_all_sync_lost();
        t_wide();
        t_mclk();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule